// File: doc/BRIEF.md
# Coprocessor Command and Status Controller

This block is the control and status front end of a microprogrammed image coprocessor. A host programs a parameter-block pointer and a microprogram start address, then writes the run bit in the control/status word. The controller then enables the microsequencer clock and emits a one-cycle start-fetch pulse. The pulse carries the start address, the pointer and the operation number decoded from the start address. The start address is a word offset from a microprogram base: 0 loads coefficients, 1 is horizontal scaling, 2 is vertical scaling and 3 is horizontal scaling with colour conversion and overlay.

While running, the microcode can post a 16-bit completion code and 4 error flags, set the done flag, stop the run and request power-down. The done flag, gated by an interrupt-enable bit, drives a level interrupt. The host acknowledges it with a separate bit. A power-down request takes effect once the unit is no longer running. It holds until the hardware reset.

A three-state machine is the run flag. In `ST_IDLE` the unit waits. A host run write takes it to `ST_RUN` (transition *launch*). In `ST_IDLE`, a pending power-down request takes it to `ST_PWRDN` (*park*) and takes priority over a run write. `ST_RUN` goes to `ST_IDLE` on a host stop write or a microcode stop (*finish*). If a power-down request is already latched, it goes to `ST_PWRDN` instead (*finish-park*). `ST_PWRDN` is left only through the asynchronous reset.

Top module: `cop_cmd_ctrl`

## Requirements
- R1: After hardware reset (`rst_n` low) the status word reads 0, both pointers read 0, and `seq_clk_en`, `irq`, `start_pulse` and `pwr_down` are 0.
- R2: A control write (host address 2) with bit 0 = 1 while idle and not power-down-pending gives the following on the next cycle: the run bit reads 1 and `start_pulse` is high for exactly that one cycle.
- R3: `seq_clk_en` equals the run bit (status bit 0). It drops the cycle after a control write with bit 0 = 0 or a `seq_clr_busy` while running.
- R4: `irq` is high exactly when done (status bit 1) and interrupt enable (status bit 4) are both 1. Control bit 4 writes the enable. Control bit 3 = 1 clears done.
- R5: A control write with bit 1 = 1 sets done, which forces the interrupt when it is enabled.
- R6: A control write with bit 2 = 1 and bit 0 = 0 is a software reset. It clears run, done, code and error flags. With bit 0 = 1 the reset field has no effect.
- R7: The status word holds the code in bits 31:16 and the error flags in bits 15:12, written by `seq_post`. Host writes cannot set them.
- R8: `seq_pwdn_req` while running sets status bit 8. Once the unit is not running, `pwr_down` rises, `seq_clk_en` stays 0 and run writes are ignored. Only `rst_n` clears it.
- R9: `start_op` is bits 3:2 of (`start_addr` − `UCODE_BASE`). `start_op_valid` is 1 only when that offset is 0, 4, 8 or 12.
- R10: Writes to the pointer (host address 0) and start address (host address 1) are ignored while running.
- R11: When writes meet in one cycle, a host clear beats a microcode update. A control write with bit 3 = 1 clears done even if `seq_set_done` is high. A microcode stop beats a host run write.
- R12: `seq_set_done`, `seq_post` and `seq_pwdn_req` have no effect unless the unit is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 2 | Write target: 0 pointer, 1 start address, 2 control |
| host_wr_data | input | 32 | Host write data |
| host_rd_addr | input | 2 | Read select: 0 pointer, 1 start address, 2 status |
| host_rd_data | output | 32 | Read data for `host_rd_addr` |
| seq_clr_busy | input | 1 | Microcode stops the run |
| seq_set_done | input | 1 | Microcode sets done |
| seq_post | input | 1 | Microcode writes code and error flags |
| seq_code | input | 16 | Completion code |
| seq_err | input | 4 | Error flags |
| seq_pwdn_req | input | 1 | Microcode power-down request |
| seq_clk_en | output | 1 | Microsequencer clock enable |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 1 | One-cycle start-fetch pulse |
| start_addr | output | 32 | Latched microprogram start address |
| param_ptr | output | 32 | Latched parameter-block pointer |
| start_op | output | 2 | Operation number decoded from the start address |
| start_op_valid | output | 1 | Start address is one of the four entry points |
| pwr_down | output | 1 | Unit is powered down |

## Verification
The hardest situations to reach are the same-cycle collisions between host and microcode: an acknowledge arriving in the very cycle the microcode sets done, a stop racing a run write, and a power-down request posted together with the microcode stop. Reaching the last one needs the *finish* transition followed by *park*, one cycle later. The stimulus drives host and microcode inputs together in one cycle, on purpose, for each of these pairs. A behavioural model in the bench tracks every register on every clock, so the ordering of each collision is checked cycle by cycle. Power-down is entered last, then the hardware reset is pulsed mid-stream to prove it is the only way out.

// File: rtl/cop_ctrl_pkg.sv
package cop_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PWRDN = 2'd2
    } run_state_e;

    localparam int DATA_W = 32;
    localparam int CODE_W = 16;
    localparam int ERR_W  = 4;

    localparam logic [1:0] RA_PTR   = 2'd0;
    localparam logic [1:0] RA_START = 2'd1;
    localparam logic [1:0] RA_CTRL  = 2'd2;

    localparam int CB_BUSY  = 0;
    localparam int CB_DONE  = 1;
    localparam int CB_SRST  = 2;
    localparam int CB_ACK   = 3;
    localparam int CB_IRQEN = 4;

    localparam int SB_PWDN = 8;
    localparam int SB_ERR  = 12;
    localparam int SB_CODE = 16;
endpackage

// File: rtl/cop_run_fsm.sv
module cop_run_fsm
    import cop_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_run_wr,
    input  logic host_run_val,
    input  logic seq_clr_busy,
    input  logic pwdn_req,
    output logic busy,
    output logic seq_clk_en,
    output logic start_pulse,
    output logic pwr_down
);
    run_state_e state_q, state_d;
    logic       pulse_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pwdn_req)
                    state_d = ST_PWRDN;
                else if (host_run_wr && host_run_val)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if ((host_run_wr && !host_run_val) || seq_clr_busy)
                    state_d = pwdn_req ? ST_PWRDN : ST_IDLE;
            end
            ST_PWRDN: state_d = ST_PWRDN;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (state_q == ST_IDLE) && (state_d == ST_RUN);
    end

    always_comb begin
        busy        = (state_q == ST_RUN);
        seq_clk_en  = (state_q == ST_RUN);
        pwr_down    = (state_q == ST_PWRDN);
        start_pulse = pulse_q;
    end

    // R2: start-fetch pulse lasts one cycle and only during a run
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    a_r2_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);
    // R8: power-down is left only by hardware reset
    a_r8_pwdn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> pwr_down);
endmodule

// File: rtl/cop_status_regs.sv
module cop_status_regs
    import cop_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_data,
    input  logic              running,
    input  logic              seq_set_done,
    input  logic              seq_post,
    input  logic [CODE_W-1:0] seq_code,
    input  logic [ERR_W-1:0]  seq_err,
    input  logic              seq_pwdn_req,
    output logic              done,
    output logic              irq_en,
    output logic [CODE_W-1:0] code,
    output logic [ERR_W-1:0]  err,
    output logic              pwdn_req
);
    logic h_srst, h_ack, h_set;

    always_comb begin
        h_srst = ctrl_wr && ctrl_data[CB_SRST] && !ctrl_data[CB_BUSY];
        h_ack  = ctrl_wr && ctrl_data[CB_ACK];
        h_set  = ctrl_wr && ctrl_data[CB_DONE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            irq_en   <= 1'b0;
            code     <= '0;
            err      <= '0;
            pwdn_req <= 1'b0;
        end else begin
            if (h_srst || h_ack)
                done <= 1'b0;
            else if (h_set || (running && seq_set_done))
                done <= 1'b1;
            if (ctrl_wr)
                irq_en <= ctrl_data[CB_IRQEN];
            if (h_srst) begin
                code <= '0;
                err  <= '0;
            end else if (running && seq_post) begin
                code <= seq_code;
                err  <= seq_err;
            end
            if (running && seq_pwdn_req)
                pwdn_req <= 1'b1;
        end
    end

    // R4 / R11: acknowledge always wins over a done set
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_data[CB_ACK]) |=> !done);
    // R8: power-down request is sticky
    a_r8_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn_req |=> pwdn_req);
endmodule

// File: rtl/cop_ptr_regs.sv
module cop_ptr_regs
    import cop_ctrl_pkg::*;
#(
    parameter logic [DATA_W-1:0] UCODE_BASE = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] param_ptr,
    output logic [DATA_W-1:0] start_addr,
    output logic [1:0]        start_op,
    output logic              start_op_valid
);
    localparam int OP_SPAN = 16;
    logic [DATA_W-1:0] offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            param_ptr  <= '0;
            start_addr <= '0;
        end else if (wr_en && !busy) begin
            if (wr_addr == RA_PTR)   param_ptr  <= wr_data;
            if (wr_addr == RA_START) start_addr <= wr_data;
        end
    end

    always_comb begin
        offset         = start_addr - UCODE_BASE;
        start_op       = offset[3:2];
        start_op_valid = (offset < DATA_W'(OP_SPAN)) && (offset[1:0] == 2'b00);
    end

    // R10: pointers frozen during a run
    a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(param_ptr) && $stable(start_addr)));
endmodule

// File: rtl/cop_cmd_ctrl.sv
module cop_cmd_ctrl
    import cop_ctrl_pkg::*;
#(
    parameter logic [31:0] UCODE_BASE = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [1:0]  host_wr_addr,
    input  logic [31:0] host_wr_data,
    input  logic [1:0]  host_rd_addr,
    output logic [31:0] host_rd_data,
    input  logic        seq_clr_busy,
    input  logic        seq_set_done,
    input  logic        seq_post,
    input  logic [15:0] seq_code,
    input  logic [3:0]  seq_err,
    input  logic        seq_pwdn_req,
    output logic        seq_clk_en,
    output logic        irq,
    output logic        start_pulse,
    output logic [31:0] start_addr,
    output logic [31:0] param_ptr,
    output logic [1:0]  start_op,
    output logic        start_op_valid,
    output logic        pwr_down
);
    logic              ctrl_wr;
    logic              busy;
    logic              done, irq_en, pwdn_req;
    logic [CODE_W-1:0] code;
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] status;

    assign ctrl_wr = host_wr_en && (host_wr_addr == RA_CTRL);

    cop_run_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_run_wr  (ctrl_wr),
        .host_run_val (host_wr_data[CB_BUSY]),
        .seq_clr_busy (seq_clr_busy),
        .pwdn_req     (pwdn_req),
        .busy         (busy),
        .seq_clk_en   (seq_clk_en),
        .start_pulse  (start_pulse),
        .pwr_down     (pwr_down)
    );

    cop_status_regs u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_data    (host_wr_data),
        .running      (busy),
        .seq_set_done (seq_set_done),
        .seq_post     (seq_post),
        .seq_code     (seq_code),
        .seq_err      (seq_err),
        .seq_pwdn_req (seq_pwdn_req),
        .done         (done),
        .irq_en       (irq_en),
        .code         (code),
        .err          (err),
        .pwdn_req     (pwdn_req)
    );

    cop_ptr_regs #(.UCODE_BASE(UCODE_BASE)) u_ptr (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy           (busy),
        .wr_en          (host_wr_en),
        .wr_addr        (host_wr_addr),
        .wr_data        (host_wr_data),
        .param_ptr      (param_ptr),
        .start_addr     (start_addr),
        .start_op       (start_op),
        .start_op_valid (start_op_valid)
    );

    always_comb begin
        status                          = '0;
        status[SB_CODE +: CODE_W]       = code;
        status[SB_ERR +: ERR_W]         = err;
        status[SB_PWDN]                 = pwdn_req;
        status[CB_IRQEN]                = irq_en;
        status[CB_DONE]                 = done;
        status[CB_BUSY]                 = busy;
        irq                             = done && irq_en;
        unique case (host_rd_addr)
            RA_PTR:   host_rd_data = param_ptr;
            RA_START: host_rd_data = start_addr;
            RA_CTRL:  host_rd_data = status;
            default:  host_rd_data = '0;
        endcase
    end

    // R3: clock enable falls after a host stop
    a_r3_stop_drops_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !host_wr_data[CB_BUSY]) |=> !seq_clk_en);
endmodule

// File: tb/tb_cop_cmd_ctrl.sv
module tb_cop_cmd_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [1:0]  host_wr_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic [1:0]  host_rd_addr = 2'd2;
    logic [31:0] host_rd_data;
    logic        seq_clr_busy = 1'b0, seq_set_done = 1'b0, seq_post = 1'b0;
    logic [15:0] seq_code = '0;
    logic [3:0]  seq_err = '0;
    logic        seq_pwdn_req = 1'b0;
    logic        seq_clk_en, irq, start_pulse, start_op_valid, pwr_down;
    logic [31:0] start_addr, param_ptr;
    logic [1:0]  start_op;

    int n_chk = 0;
    int n_fail = 0;

    cop_cmd_ctrl #(.UCODE_BASE(BASE)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: 0 idle, 1 run, 2 powered down
    int          m_state;
    bit          m_done, m_irqen, m_pwdn, m_pulse;
    logic [15:0] m_code;
    logic [3:0]  m_err;
    logic [31:0] m_ptr, m_start;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_done = 0; m_irqen = 0; m_pwdn = 0; m_pulse = 0;
            m_code = 0; m_err = 0; m_ptr = 0; m_start = 0;
        end else begin
            bit wc, run, srst, stop;
            int nxt;
            wc   = host_wr_en && host_wr_addr == 2'd2;
            run  = (m_state == 1);
            srst = wc && host_wr_data[2] && !host_wr_data[0];
            stop = (wc && !host_wr_data[0]) || seq_clr_busy;
            nxt  = m_state;
            if (m_state == 0) begin
                if (m_pwdn) nxt = 2;
                else if (wc && host_wr_data[0]) nxt = 1;
            end else if (m_state == 1 && stop) begin
                nxt = m_pwdn ? 2 : 0;
            end
            m_pulse = (m_state == 0 && nxt == 1);
            if (srst || (wc && host_wr_data[3])) m_done = 0;
            else if ((wc && host_wr_data[1]) || (run && seq_set_done)) m_done = 1;
            if (wc) m_irqen = host_wr_data[4];
            if (srst) begin m_code = 0; m_err = 0; end
            else if (run && seq_post) begin m_code = seq_code; m_err = seq_err; end
            if (run && seq_pwdn_req) m_pwdn = 1;
            if (!run && host_wr_en && host_wr_addr == 2'd0) m_ptr = host_wr_data;
            if (!run && host_wr_en && host_wr_addr == 2'd1) m_start = host_wr_data;
            m_state = nxt;
        end
    end

    function automatic logic [31:0] m_status();
        return {m_code, m_err, 3'b0, m_pwdn, 3'b0, m_irqen, 2'b0, m_done, (m_state == 1)};
    endfunction

    function automatic logic [31:0] m_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_ptr;
            2'd1:    return m_start;
            2'd2:    return m_status();
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [31:0] off;
            off = m_start - BASE;
            chk("R3 clk_en", {31'b0, seq_clk_en}, {31'b0, m_state == 1});
            chk("R8 pwr_down", {31'b0, pwr_down}, {31'b0, m_state == 2});
            chk("R4 irq", {31'b0, irq}, {31'b0, m_done && m_irqen});
            chk("R2 start_pulse", {31'b0, start_pulse}, {31'b0, m_pulse});
            chk("R10 param_ptr", param_ptr, m_ptr);
            chk("R10 start_addr", start_addr, m_start);
            chk("R9 start_op", {30'b0, start_op}, {30'b0, off[3:2]});
            chk("R9 op_valid", {31'b0, start_op_valid},
                {31'b0, (off < 32'd16) && (off[1:0] == 2'b00)});
            chk("R7 rd_data", host_rd_data, m_rd(host_rd_addr));
        end
    end

    task automatic cyc(input bit we, input logic [1:0] a, input logic [31:0] d,
                       input bit clr, input bit setd, input bit post,
                       input logic [15:0] c, input logic [3:0] e, input bit pw);
        @(negedge clk);
        host_wr_en = we; host_wr_addr = a; host_wr_data = d;
        seq_clr_busy = clr; seq_set_done = setd; seq_post = post;
        seq_code = c; seq_err = e; seq_pwdn_req = pw;
        @(negedge clk);
        host_wr_en = 0; host_wr_data = 0; seq_clr_busy = 0; seq_set_done = 0;
        seq_post = 0; seq_pwdn_req = 0; seq_code = 0; seq_err = 0;
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle_cyc();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", host_rd_data, 32'h0);
        chk("R1 outputs", {28'b0, seq_clk_en, irq, start_pulse, pwr_down}, 32'h0);
        chk("R1 ptr", param_ptr, 32'h0);

        hw(2'd0, 32'h2000_0040);
        hw(2'd1, BASE + 32'd8);
        chk("R9 op vertical", {29'b0, start_op_valid, start_op}, {29'b0, 1'b1, 2'd2});
        hw(2'd2, 32'h11);                       // run, irq enable
        chk("R2 pulse", {31'b0, start_pulse}, 32'h1);
        chk("R2 run bit", {31'b0, host_rd_data[0]}, 32'h1);
        idle_cyc();
        chk("R2 pulse one cycle", {31'b0, start_pulse}, 32'h0);
        hw(2'd0, 32'hDEAD_0000);                // ignored while running
        chk("R10 ptr frozen", param_ptr, 32'h2000_0040);
        cyc(0, 0, 0, 1, 1, 1, 16'hBEEF, 4'h5, 0);
        chk("R7 code/err", host_rd_data & 32'hFFFF_F000, 32'hBEEF_5000);
        chk("R3 clk_en dropped", {31'b0, seq_clk_en}, 32'h0);
        chk("R4 irq raised", {31'b0, irq}, 32'h1);
        hw(2'd2, 32'hFFFF_F018);                // ack; high bits must not land in code
        chk("R4 ack", {31'b0, irq}, 32'h0);
        chk("R7 host cannot write code", host_rd_data & 32'hFFFF_F000, 32'hBEEF_5000);
        hw(2'd2, 32'h12);
        chk("R5 forced irq", {31'b0, irq}, 32'h1);
        hw(2'd2, 32'h18);
        // R12 microcode inputs while idle
        cyc(0, 0, 0, 0, 1, 1, 16'h1234, 4'hA, 1);
        chk("R12 idle ignored", host_rd_data, 32'hBEEF_5010);
        // R11 collisions
        hw(2'd2, 32'h11);
        cyc(1, 2'd2, 32'h19, 0, 1, 0, 0, 0, 0);
        chk("R11 ack beats seq done", {30'b0, host_rd_data[1:0]}, 32'h1);
        cyc(1, 2'd2, 32'h11, 1, 0, 0, 0, 0, 0);
        chk("R11 seq stop beats run write", {31'b0, seq_clk_en}, 32'h0);
        // R6 software reset, ignored when run bit written 1
        hw(2'd2, 32'h11);
        cyc(0, 0, 0, 0, 1, 1, 16'h00C3, 4'h2, 0);
        hw(2'd2, 32'h15);
        chk("R6 reset ignored with run", host_rd_data, 32'h00C3_2013);
        hw(2'd2, 32'h04);
        chk("R6 soft reset", host_rd_data, 32'h0);
        // R9 decode corners
        hw(2'd1, BASE + 32'd2);
        chk("R9 misaligned", {31'b0, start_op_valid}, 32'h0);
        hw(2'd1, BASE + 32'd16);
        chk("R9 past end", {31'b0, start_op_valid}, 32'h0);
        hw(2'd1, BASE + 32'd12);
        chk("R9 op 3", {29'b0, start_op_valid, start_op}, {29'b0, 1'b1, 2'd3});
        hw(2'd1, BASE);
        chk("R9 op 0", {29'b0, start_op_valid, start_op}, {29'b0, 1'b1, 2'd0});
        // R8 power-down posted with the stop
        hw(2'd2, 32'h01);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
        chk("R8 not yet down", {31'b0, pwr_down}, 32'h0);
        idle_cyc();
        chk("R8 down", {31'b0, pwr_down}, 32'h1);
        hw(2'd2, 32'h01);
        chk("R8 run ignored", {30'b0, seq_clk_en, pwr_down}, 32'h1);
        hw(2'd2, 32'h04);
        chk("R8 survives soft reset", {31'b0, host_rd_data[8]}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 R1 hard reset", {31'b0, pwr_down}, 32'h0);
        chk("R1 status after reset", host_rd_data, 32'h0);
        hw(2'd2, 32'h01);
        chk("R2 run after reset", {31'b0, seq_clk_en}, 32'h1);
        repeat (3) idle_cyc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule